// File: doc/BRIEF.md
# Diverse Replica Set Scheduler

This block keeps a set of three compute units for the task currently in flight. It draws them from a pool of tagged units. Each unit has a fixed vendor class, and no two units in the set may share a class. Identical replicas would all fail in the same way, so a majority vote between them would not catch a common fault.

The set is changed in two ways. A pseudo-random timer asks on its own schedule for one member to be rotated out, and the member it picks advances cyclically through the slots. The output arbiter can also ask for particular members to be removed. A member removed at the arbiter's request leaves the pool until a cleaning-complete strobe returns it. Both kinds of request are held until the current task ends and are then applied one slot per idle cycle. If no unit can legally fill a slot, the block keeps the set it has and raises a starvation flag.

The class of each unit is a build-time parameter. The set present after reset is worked out from that class table while the design is elaborated.

Top module: `replica_map_sched`

## Requirements
- R1: After reset, the set in slots 0, 1 and 2 is the first three units, in ascending index order, that have pairwise different classes. With the default table, where unit u has class u mod 4, that set is units 0, 1 and 2. All units are in the pool, `starve_o` is 0 and `remap_o` is 0.
- R2: At all times, the three units on `map_o` have pairwise different classes. Slot k occupies bits [k*ID_W +: ID_W].
- R3: `map_o` changes only at a clock edge where `task_busy_i` is low. Requests that arrive while it is high wait until it goes low.
- R4: When `fb_valid_i` is high, bit k of `fb_swap_mask_i` asks for slot k to be replaced. Replacements start at the edge after the request and are served lowest slot first, one per idle cycle. The new unit is the lowest-indexed unit that is in the pool, is not the unit being replaced, and has a class different from both other slots. The replaced unit's bit in `avail_o` drops to 0.
- R5: A feedback request with an all-zero mask changes neither `map_o` nor `avail_o`.
- R6: A `clean_done_i` pulse sets bit `clean_unit_i` of `avail_o` at the next edge, which makes that unit eligible again.
- R7: If no unit is eligible for the slot being served, `map_o` holds, `starve_o` rises and the request stays pending. The request is served at the first idle edge at which a candidate exists, and `starve_o` then returns to 0.
- R8: If `max_interval_i` is 0, the timer does nothing. Otherwise it fires at the edge where its cycle count (starting at 0) reaches min(L, `max_interval_i`), where L is a 16-bit Galois LFSR. The LFSR is seeded with 0xACE1. It steps only when the timer fires: it shifts right and XORs in 0xB400 when the bit shifted out is 1. After each firing the count restarts at 0.
- R9: The slot served by a timer request rotates 0, 1, 2, 0, and so on. The same choice rule as in R4 applies, but the replaced unit stays in the pool. The replacement is applied at the edge after the firing when the block is idle.
- R10: If a feedback request and a timer request are pending together, the feedback request is served and the timer request is discarded.
- R11: `remap_o` is high for exactly the one cycle that follows each applied replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_busy_i | input | 1 | High while a task executes; the set is frozen |
| max_interval_i | input | 16 | Upper bound on the timer interval; 0 turns the timer off |
| fb_valid_i | input | 1 | Feedback decision from the arbiter is present |
| fb_swap_mask_i | input | 3 | Slots the arbiter wants replaced (bit k means slot k) |
| clean_done_i | input | 1 | A unit has finished cleaning |
| clean_unit_i | input | 3 | Index of the unit that finished cleaning |
| map_o | output | 9 | Unit IDs in slots 2, 1, 0 (slot 0 in the low bits) |
| avail_o | output | 8 | Bit per unit: 1 means the unit is in the pool |
| starve_o | output | 1 | A pending replacement has no eligible unit |
| remap_o | output | 1 | One-cycle pulse after a replacement was applied |

## Verification
A corrupted slot register appears on `map_o` at once. It shows up either as two slots sharing a class or as a mapped unit whose `avail_o` bit is clear, so it is visible in the same cycle. A wrong pending-request state shows up one idle cycle later: an expected replacement is missing, an extra one appears, or the wrong slot is served. A wrong LFSR or interval counter shows up as a `remap_o` pulse that comes early or late, measured in clock edges, against intervals the bench derives from the LFSR sequence. Starvation bookkeeping is visible through `starve_o` and through the cycle in which a cleaned unit is taken back into the set.

// File: rtl/rms_pkg.sv
`timescale 1ns/1ps
package rms_pkg;
  localparam int REPLICAS = 3;
  typedef logic [1:0] slot_t;

  function automatic slot_t slot_after(slot_t s);
    return (s == slot_t'(REPLICAS - 1)) ? slot_t'(0) : s + 2'd1;
  endfunction

  function automatic slot_t slot_before(slot_t s);
    return (s == slot_t'(0)) ? slot_t'(REPLICAS - 1) : s - 2'd1;
  endfunction

  function automatic slot_t lowest_slot(logic [REPLICAS-1:0] m);
    slot_t r;
    r = '0;
    for (int i = REPLICAS - 1; i >= 0; i--) begin
      if (m[i]) r = slot_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/rms_timer.sv
`timescale 1ns/1ps
module rms_timer #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] max_i,
  output logic         fire_o
);
  logic [W-1:0] lfsr_q, cnt_q, limit;

  assign limit  = (lfsr_q < max_i) ? lfsr_q : max_i;
  assign fire_o = (max_i != '0) && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= SEED;
      cnt_q  <= '0;
    end else begin
      if (max_i == '0 || fire_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
      if (fire_o) lfsr_q <= {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? POLY : '0);
    end
  end
endmodule

// File: rtl/rms_pick.sv
`timescale 1ns/1ps
module rms_pick #(
  parameter int NUM_UNITS = 8,
  parameter int CLASS_W   = 2,
  parameter logic [NUM_UNITS*CLASS_W-1:0] UNIT_CLASS = '0
) (
  input  logic [NUM_UNITS-1:0]         avail_i,
  input  logic [CLASS_W-1:0]           keep_a_cls_i,
  input  logic [CLASS_W-1:0]           keep_b_cls_i,
  input  logic [$clog2(NUM_UNITS)-1:0] self_id_i,
  output logic                         found_o,
  output logic [$clog2(NUM_UNITS)-1:0] pick_o
);
  localparam int ID_W = $clog2(NUM_UNITS);
  logic [NUM_UNITS-1:0] elig;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_elig
    localparam logic [CLASS_W-1:0] UC = UNIT_CLASS[u*CLASS_W +: CLASS_W];
    assign elig[u] = avail_i[u] && (UC != keep_a_cls_i) && (UC != keep_b_cls_i)
                     && (self_id_i != ID_W'(u));
  end

  always_comb begin
    pick_o = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (elig[u]) pick_o = ID_W'(u);
    end
  end

  assign found_o = |elig;
endmodule

// File: rtl/rms_pool.sv
`timescale 1ns/1ps
module rms_pool #(
  parameter int NUM_UNITS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         back_en_i,
  input  logic [$clog2(NUM_UNITS)-1:0] back_id_i,
  input  logic                         out_en_i,
  input  logic [$clog2(NUM_UNITS)-1:0] out_id_i,
  output logic [NUM_UNITS-1:0]         avail_o
);
  logic [NUM_UNITS-1:0] avail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= '1;
    end else begin
      if (back_en_i) avail_q[back_id_i] <= 1'b1;
      if (out_en_i)  avail_q[out_id_i]  <= 1'b0;
    end
  end

  assign avail_o = avail_q;
endmodule

// File: rtl/replica_map_sched.sv
`timescale 1ns/1ps
module replica_map_sched
  import rms_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int CLASS_W   = 2,
  parameter int TMR_W     = 16,
  parameter logic [NUM_UNITS*CLASS_W-1:0] UNIT_CLASS = 16'hE4E4,
  parameter logic [TMR_W-1:0] LFSR_POLY = 16'hB400,
  parameter logic [TMR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    task_busy_i,
  input  logic [TMR_W-1:0]                        max_interval_i,
  input  logic                                    fb_valid_i,
  input  logic [REPLICAS-1:0]                     fb_swap_mask_i,
  input  logic                                    clean_done_i,
  input  logic [$clog2(NUM_UNITS)-1:0]            clean_unit_i,
  output logic [REPLICAS*$clog2(NUM_UNITS)-1:0]   map_o,
  output logic [NUM_UNITS-1:0]                    avail_o,
  output logic                                    starve_o,
  output logic                                    remap_o
);
  localparam int ID_W = $clog2(NUM_UNITS);
  typedef logic [ID_W-1:0] uid_t;

  function automatic logic [CLASS_W-1:0] cls_of(uid_t id);
    return UNIT_CLASS[int'(id)*CLASS_W +: CLASS_W];
  endfunction

  function automatic logic [REPLICAS*ID_W-1:0] first_diverse();
    logic [REPLICAS*ID_W-1:0]          m;
    logic [REPLICAS-1:0][CLASS_W-1:0]  seen;
    logic [CLASS_W-1:0]                c;
    logic                              ok;
    int                                n;
    m = '0; seen = '0; n = 0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      c  = UNIT_CLASS[u*CLASS_W +: CLASS_W];
      ok = (n < REPLICAS);
      for (int k = 0; k < REPLICAS; k++) begin
        if (k < n && seen[k] == c) ok = 1'b0;
      end
      if (ok) begin
        m[n*ID_W +: ID_W] = ID_W'(u);
        seen[n] = c;
        n++;
      end
    end
    return m;
  endfunction

  localparam logic [REPLICAS*ID_W-1:0] RESET_MAP = first_diverse();

  logic [REPLICAS-1:0][ID_W-1:0] slot_q;
  logic [REPLICAS-1:0]           fb_pend_q;
  logic                          rnd_pend_q;
  slot_t                         rr_q;
  logic                          starve_q, remap_q;

  logic                 fire, sel_fb, want, found, commit;
  slot_t                tgt;
  uid_t                 pick_id, self_id;
  logic [CLASS_W-1:0]   keep_a_cls, keep_b_cls;
  logic [NUM_UNITS-1:0] avail;
  logic [REPLICAS-1:0]  tgt_1h;

  rms_timer #(.W(TMR_W), .POLY(LFSR_POLY), .SEED(LFSR_SEED)) u_timer (
    .clk(clk), .rst(rst), .max_i(max_interval_i), .fire_o(fire)
  );

  always_comb begin
    sel_fb     = |fb_pend_q;
    tgt        = sel_fb ? lowest_slot(fb_pend_q) : rr_q;
    want       = !task_busy_i && (sel_fb || rnd_pend_q);
    self_id    = slot_q[tgt];
    keep_a_cls = cls_of(slot_q[slot_after(tgt)]);
    keep_b_cls = cls_of(slot_q[slot_before(tgt)]);
    tgt_1h     = {{(REPLICAS-1){1'b0}}, 1'b1} << tgt;
  end

  rms_pick #(.NUM_UNITS(NUM_UNITS), .CLASS_W(CLASS_W), .UNIT_CLASS(UNIT_CLASS)) u_pick (
    .avail_i(avail), .keep_a_cls_i(keep_a_cls), .keep_b_cls_i(keep_b_cls),
    .self_id_i(self_id), .found_o(found), .pick_o(pick_id)
  );

  assign commit = want && found;

  rms_pool #(.NUM_UNITS(NUM_UNITS)) u_pool (
    .clk(clk), .rst(rst),
    .back_en_i(clean_done_i), .back_id_i(clean_unit_i),
    .out_en_i(commit && sel_fb), .out_id_i(self_id),
    .avail_o(avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= RESET_MAP;
      fb_pend_q  <= '0;
      rnd_pend_q <= 1'b0;
      rr_q       <= '0;
      starve_q   <= 1'b0;
      remap_q    <= 1'b0;
    end else begin
      remap_q    <= commit;
      fb_pend_q  <= (fb_pend_q & ~((commit && sel_fb) ? tgt_1h : '0))
                    | (fb_valid_i ? fb_swap_mask_i : '0);
      rnd_pend_q <= (rnd_pend_q && !commit) || fire;
      if (commit) begin
        slot_q[tgt] <= pick_id;
        if (!sel_fb) rr_q <= slot_after(rr_q);
      end
      if (want)              starve_q <= !found;
      else if (!task_busy_i) starve_q <= 1'b0;
    end
  end

  assign map_o    = slot_q;
  assign avail_o  = avail;
  assign starve_o = starve_q;
  assign remap_o  = remap_q;
endmodule

// File: rtl/replica_map_sched_chk.sv
`timescale 1ns/1ps
module replica_map_sched_chk
  import rms_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int CLASS_W   = 2,
  parameter logic [NUM_UNITS*CLASS_W-1:0] UNIT_CLASS = 16'hE4E4
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  task_busy_i,
  input logic [REPLICAS*$clog2(NUM_UNITS)-1:0] map_o,
  input logic [NUM_UNITS-1:0]                  avail_o,
  input logic                                  starve_o,
  input logic                                  remap_o
);
  localparam int ID_W = $clog2(NUM_UNITS);

  logic [ID_W-1:0]    u0, u1, u2;
  logic [CLASS_W-1:0] c0, c1, c2;
  assign u0 = map_o[0*ID_W +: ID_W];
  assign u1 = map_o[1*ID_W +: ID_W];
  assign u2 = map_o[2*ID_W +: ID_W];
  assign c0 = UNIT_CLASS[int'(u0)*CLASS_W +: CLASS_W];
  assign c1 = UNIT_CLASS[int'(u1)*CLASS_W +: CLASS_W];
  assign c2 = UNIT_CLASS[int'(u2)*CLASS_W +: CLASS_W];

  // R2: replica classes pairwise distinct
  p_distinct_class_r2: assert property (@(posedge clk) disable iff (rst)
    (c0 != c1) && (c0 != c2) && (c1 != c2));

  // R3: set frozen across an edge where a task is running
  p_busy_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    task_busy_i |=> $stable(map_o));

  // R4: every mapped unit is a member of the pool
  p_mapped_in_pool_r4: assert property (@(posedge clk) disable iff (rst)
    avail_o[u0] && avail_o[u1] && avail_o[u2]);

  // R7: starvation never coincides with a change of the set
  p_starve_holds_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(starve_o) && !$past(rst) |-> $stable(map_o));

  // R11: pulse marks a real change, and no change happens without it
  p_remap_marks_r11: assert property (@(posedge clk) disable iff (rst)
    remap_o |-> !$stable(map_o));
  p_quiet_no_change_r11: assert property (@(posedge clk) disable iff (rst)
    !remap_o && !$past(rst) |-> $stable(map_o));

  // R3: an applied change was decided while idle
  p_remap_idle_r3: assert property (@(posedge clk) disable iff (rst)
    remap_o |-> !$past(task_busy_i));
endmodule

bind replica_map_sched replica_map_sched_chk #(
  .NUM_UNITS(NUM_UNITS), .CLASS_W(CLASS_W), .UNIT_CLASS(UNIT_CLASS)
) u_chk (
  .clk(clk), .rst(rst), .task_busy_i(task_busy_i), .map_o(map_o),
  .avail_o(avail_o), .starve_o(starve_o), .remap_o(remap_o)
);

// File: tb/replica_map_sched_test.sv
`timescale 1ns/1ps
module replica_map_sched_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busy = 1'b0;
  logic [15:0] max_iv = '0;
  logic        fb_valid = 1'b0;
  logic [2:0]  fb_mask = '0;
  logic        clean_done = 1'b0;
  logic [2:0]  clean_unit = '0;
  logic [8:0]  map_o;
  logic [7:0]  avail_o;
  logic        starve_o, remap_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int e_map[3];
  logic [7:0] e_avail;

  always #2 clk = ~clk;

  replica_map_sched uut (
    .clk(clk), .rst(rst), .task_busy_i(busy), .max_interval_i(max_iv),
    .fb_valid_i(fb_valid), .fb_swap_mask_i(fb_mask),
    .clean_done_i(clean_done), .clean_unit_i(clean_unit),
    .map_o(map_o), .avail_o(avail_o), .starve_o(starve_o), .remap_o(remap_o)
  );

  function automatic int ucls(int u);
    return u % 4;
  endfunction

  function automatic int pick(int s);
    int o1, o2;
    o1 = e_map[(s + 1) % 3];
    o2 = e_map[(s + 2) % 3];
    for (int i = 0; i < 8; i++) begin
      if (e_avail[i] && ucls(i) != ucls(o1) && ucls(i) != ucls(o2) && i != e_map[s])
        return i;
    end
    return -1;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    int a, b, c;
    for (int s = 0; s < 3; s++) chk({tag, " slot"}, int'(map_o[s*3 +: 3]), e_map[s]);
    chk({tag, " pool"}, int'(avail_o), int'(e_avail));
    a = ucls(int'(map_o[2:0])); b = ucls(int'(map_o[5:3])); c = ucls(int'(map_o[8:6]));
    chk("R2 distinct classes", int'(a != b && a != c && b != c), 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    e_map[0] = 0; e_map[1] = 1; e_map[2] = 2;
    e_avail = 8'hFF;
  endtask

  task automatic send_fb(input logic [2:0] m);
    fb_valid = 1'b1; fb_mask = m;
    step();
    fb_valid = 1'b0; fb_mask = '0;
  endtask

  // R4/R7: one idle edge serves slot s by feedback
  task automatic expect_apply(input int s, input string tag);
    int p, old;
    p = pick(s);
    step();
    if (p >= 0) begin
      old = e_map[s];
      e_map[s] = p;
      e_avail[old] = 1'b0;
      chk({tag, " R11 pulse"}, int'(remap_o), 1);
      chk({tag, " R7 no starve"}, int'(starve_o), 0);
    end else begin
      chk({tag, " R7 starve"}, int'(starve_o), 1);
      chk({tag, " R7 no pulse"}, int'(remap_o), 0);
    end
    check_state(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R8 actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check_state("R1 reset");
    chk("R1 starve", int'(starve_o), 0);
    chk("R1 remap", int'(remap_o), 0);
    // R8 timer off
    repeat (5) step();
    check_state("R8 timer off");
    chk("R8 no pulse", int'(remap_o), 0);

    // R8/R9 timer intervals and rotation
    max_iv = 16'h2000;
    lf = 16'hACE1;
    for (int f = 0; f < 6; f++) begin
      int lim, want, k, p, s;
      lim  = (lf < 16'h2000) ? int'(lf) : 32'h2000;
      want = (f == 0) ? lim + 2 : lim;
      k = 0;
      do begin
        step();
        k++;
      end while (!remap_o && k < want + 4);
      chk("R8 interval", k, want);
      s = f % 3;
      p = pick(s);
      e_map[s] = p;
      check_state("R9 rotate");
      step();
      chk("R11 single pulse", int'(remap_o), 0);
      lf = {1'b0, lf[15:1]} ^ (lf[0] ? 16'hB400 : 16'h0000);
    end
    max_iv = '0;

    do_reset();
    // R4 single feedback replacement
    send_fb(3'b001);
    check_state("R4 latched only");
    expect_apply(0, "R4 slot0");

    // R5 zero mask
    send_fb(3'b000);
    repeat (4) step();
    chk("R5 no pulse", int'(remap_o), 0);
    check_state("R5 zero mask");

    // R3 frozen while busy, then lowest slot first
    busy = 1'b1;
    send_fb(3'b110);
    repeat (5) begin
      step();
      chk("R3 no pulse", int'(remap_o), 0);
      check_state("R3 busy");
    end
    busy = 1'b0;
    expect_apply(1, "R4 slot1");
    expect_apply(2, "R4 slot2");

    // R7 starvation and R6 recovery
    send_fb(3'b111);
    expect_apply(0, "R7 s0");
    expect_apply(1, "R7 s1");
    expect_apply(2, "R7 s2");
    chk("R7 starving", int'(starve_o), 1);
    repeat (3) begin
      step();
      chk("R7 held", int'(starve_o), 1);
      check_state("R7 held");
    end
    clean_done = 1'b1; clean_unit = 3'd0;
    step();
    clean_done = 1'b0;
    e_avail[0] = 1'b1;
    chk("R6 returned", int'(avail_o[0]), 1);
    chk("R7 still starving", int'(starve_o), 1);
    expect_apply(2, "R6 reuse");
    chk("R7 cleared", int'(starve_o), 0);

    // R10 feedback beats a pending timer request
    for (int u = 1; u <= 5; u++) begin
      clean_done = 1'b1; clean_unit = 3'(u);
      step();
      e_avail[u] = 1'b1;
    end
    clean_done = 1'b0;
    check_state("R6 all back");
    busy = 1'b1;
    max_iv = 16'd1;
    repeat (4) step();
    send_fb(3'b001);
    max_iv = '0;
    step();
    check_state("R3 busy with requests");
    busy = 1'b0;
    expect_apply(0, "R10 feedback");
    repeat (6) begin
      step();
      chk("R10 timer dropped", int'(remap_o), 0);
      check_state("R10 after");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule